// File: doc/BRIEF.md
# Condition Code Flag Register

This block holds the status byte of a small 8-bit processor. Four arithmetic flags live in it: half carry, negative, zero and carry. It also holds a two-bit current interrupt level. Each cycle it takes the ALU result and carries, tagged with an operation class. It also takes explicit carry and level commands, an interrupt-entry strobe with the level to load, and a full-byte restore used by pop and return-from-interrupt.

From the stored byte it derives branch-condition signals in true and complemented form. It also gives a combinational decision on whether a pending interrupt of a given priority may be taken at the current level.

The register updates on the rising clock edge. When several sources act in one cycle, a fixed order decides which one wins: reset, then interrupt entry, then the byte restore, then explicit commands, then the ALU. The branch and accept outputs follow the stored value with no extra delay.

Top module: `ccr_core`

## Requirements
- R1: The byte `ccr_q` has bit 7 and bit 6 at 1 at all times. Bit 5 is I1, bit 4 is H, bit 3 is I0, bit 2 is N, bit 1 is Z and bit 0 is C.
- R2: A synchronous active-high `rst` loads 0xE8. This value sets {I1,I0}=11 and clears all four arithmetic flags. Reset wins over every other input.
- R3: H is loaded from `alu_h` only when `alu_op` is the add class (code 1). Every other class leaves H unchanged.
- R4: For classes add (1), arithmetic (2), logical (3) and shift (4), N takes result bit 7 and Z is 1 exactly when the result is zero. Classes none (0) and bit-test (5) leave N and Z unchanged.
- R5: C is loaded from `alu_c` for classes add, arithmetic, shift and bit-test. Classes none and logical leave C unchanged.
- R6: `set_c` forces C to 1 and `clr_c` forces C to 0, overriding the ALU carry. If both are asserted, the set wins. Neither command affects the other flags.
- R7: The level is {I1,I0}, where 10 is level 0, 01 is level 1, 00 is level 2 and 11 is level 3 (interrupts disabled). `lvl_enable` and `lvl_wait` write 10. `lvl_disable` and `lvl_halt` write 11. A disable-type command wins over an enable-type command.
- R8: `irq_enter` loads `irq_lvl` into {I1,I0} and leaves the flags unchanged. In that cycle the restore, the explicit commands and the ALU update are all ignored.
- R9: `restore_en` (without `irq_enter`) loads `restore_byte` into the register, with bits 7:6 forced to 1. In that cycle the explicit commands and the ALU update are ignored.
- R10: `irq_accept` is 1 only when `irq_pend` is 1, the rank of `req_lvl` is strictly above the current rank, and the current level is not 11. Rank is 0, 1, 2, 3 for the codes 10, 01, 00, 11.
- R11: Each pair `br_c`/`br_nc`, `br_h`/`br_nh`, `br_z`/`br_nz` and `br_mi`/`br_pl` gives C, H, Z and N in true and complemented form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_op | input | 3 | Operation class: 0 none, 1 add, 2 arithmetic, 3 logical, 4 shift, 5 bit-test |
| alu_res | input | RES_W | ALU result |
| alu_c | input | 1 | ALU carry or borrow out |
| alu_h | input | 1 | Carry from bit 3 into bit 4 |
| set_c | input | 1 | Force carry to 1 |
| clr_c | input | 1 | Force carry to 0 |
| lvl_enable | input | 1 | Write level 0 |
| lvl_wait | input | 1 | Wait-for-interrupt, writes level 0 |
| lvl_disable | input | 1 | Write level 3 |
| lvl_halt | input | 1 | Halt, writes level 3 |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_lvl | input | 2 | Level code loaded on entry |
| restore_en | input | 1 | Full-byte restore strobe |
| restore_byte | input | 8 | Byte to restore |
| irq_pend | input | 1 | An interrupt request is pending |
| req_lvl | input | 2 | Level code of the pending request |
| ccr_q | output | 8 | Register byte |
| irq_accept | output | 1 | Pending request may be taken |
| br_c | output | 1 | Carry set |
| br_nc | output | 1 | Carry clear |
| br_h | output | 1 | Half carry set |
| br_nh | output | 1 | Half carry clear |
| br_z | output | 1 | Zero set |
| br_nz | output | 1 | Zero clear |
| br_mi | output | 1 | Negative set |
| br_pl | output | 1 | Negative clear |

## Verification
The bench builds the block with its default result width of eight bits. With that width, the byte-level reset value and the restore values can be checked as exact hex values, and a sign bit at position 7 can be driven straight from the vectors. The table walks every operation class through a chain of states, so both the updated and the held flags are visible. Directed cases then stack entry, restore, level commands and ALU updates in a single cycle, to show the winning source and compare the accept decision against each level.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int CCR_W = 8;
    localparam int LVL_W = 2;

    typedef enum logic [2:0] {
        OPC_NONE    = 3'd0,
        OPC_ADD     = 3'd1,
        OPC_ARITH   = 3'd2,
        OPC_LOGIC   = 3'd3,
        OPC_SHIFT   = 3'd4,
        OPC_BITTEST = 3'd5
    } op_class_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic c;
    } arith_flags_t;

    typedef logic [LVL_W-1:0] lvl_code_t;

    localparam lvl_code_t LVL_MAIN = 2'b10;
    localparam lvl_code_t LVL_ONE  = 2'b01;
    localparam lvl_code_t LVL_TWO  = 2'b00;
    localparam lvl_code_t LVL_OFF  = 2'b11;

    typedef struct packed {
        arith_flags_t flags;
        lvl_code_t    lvl;
    } ccr_state_t;

    localparam ccr_state_t CCR_RST_STATE = '{flags: '0, lvl: LVL_OFF};

    // Rank 0..3 for level codes; higher rank is higher priority
    function automatic logic [1:0] lvl_rank(lvl_code_t code);
        logic [1:0] r;
        case (code)
            LVL_MAIN: r = 2'd0;
            LVL_ONE:  r = 2'd1;
            LVL_TWO:  r = 2'd2;
            default:  r = 2'd3;
        endcase
        return r;
    endfunction

    function automatic logic [CCR_W-1:0] ccr_pack(ccr_state_t s);
        return {2'b11, s.lvl[1], s.flags.h, s.lvl[0], s.flags.n, s.flags.z, s.flags.c};
    endfunction

    function automatic ccr_state_t ccr_unpack(logic [CCR_W-1:0] b);
        ccr_state_t s;
        s.lvl     = {b[5], b[3]};
        s.flags.h = b[4];
        s.flags.n = b[2];
        s.flags.z = b[1];
        s.flags.c = b[0];
        return s;
    endfunction

endpackage

// File: rtl/ccr_flag_next.sv
module ccr_flag_next
    import ccr_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  arith_flags_t     cur,
    input  op_class_e        op,
    input  logic [RES_W-1:0] res,
    input  logic             alu_c,
    input  logic             alu_h,
    input  logic             set_c,
    input  logic             clr_c,
    output arith_flags_t     nxt
);
    localparam int SIGN_BIT = RES_W - 1;

    logic res_neg;
    logic res_zero;

    assign res_neg  = res[SIGN_BIT];
    assign res_zero = (res == '0);

    always_comb begin
        nxt = cur;
        case (op)
            OPC_ADD: begin
                nxt.h = alu_h;
                nxt.n = res_neg;
                nxt.z = res_zero;
                nxt.c = alu_c;
            end
            OPC_ARITH, OPC_SHIFT: begin
                nxt.n = res_neg;
                nxt.z = res_zero;
                nxt.c = alu_c;
            end
            OPC_LOGIC: begin
                nxt.n = res_neg;
                nxt.z = res_zero;
            end
            OPC_BITTEST: begin
                nxt.c = alu_c;
            end
            default: ;
        endcase
        if (set_c) begin
            nxt.c = 1'b1;
        end else if (clr_c) begin
            nxt.c = 1'b0;
        end
    end
endmodule

// File: rtl/ccr_level_next.sv
module ccr_level_next
    import ccr_pkg::*;
(
    input  lvl_code_t cur,
    input  logic      lvl_enable,
    input  logic      lvl_wait,
    input  logic      lvl_disable,
    input  logic      lvl_halt,
    output lvl_code_t nxt
);
    logic mask_req;
    logic open_req;

    assign mask_req = lvl_disable | lvl_halt;
    assign open_req = lvl_enable | lvl_wait;

    always_comb begin
        if (mask_req) begin
            nxt = LVL_OFF;
        end else if (open_req) begin
            nxt = LVL_MAIN;
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate
    import ccr_pkg::*;
(
    input  lvl_code_t cur,
    input  logic      pend,
    input  lvl_code_t req,
    output logic      accept
);
    logic [1:0] cur_rank;
    logic [1:0] req_rank;
    logic       masked;

    assign cur_rank = lvl_rank(cur);
    assign req_rank = lvl_rank(req);
    assign masked   = (cur == LVL_OFF);
    assign accept   = pend && !masked && (req_rank > cur_rank);
endmodule

// File: rtl/ccr_branch.sv
module ccr_branch
    import ccr_pkg::*;
(
    input  arith_flags_t flags,
    output logic         br_c,
    output logic         br_nc,
    output logic         br_h,
    output logic         br_nh,
    output logic         br_z,
    output logic         br_nz,
    output logic         br_mi,
    output logic         br_pl
);
    assign br_c  = flags.c;
    assign br_nc = ~flags.c;
    assign br_h  = flags.h;
    assign br_nh = ~flags.h;
    assign br_z  = flags.z;
    assign br_nz = ~flags.z;
    assign br_mi = flags.n;
    assign br_pl = ~flags.n;
endmodule

// File: rtl/ccr_core.sv
module ccr_core
    import ccr_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       alu_op,
    input  logic [RES_W-1:0] alu_res,
    input  logic             alu_c,
    input  logic             alu_h,
    input  logic             set_c,
    input  logic             clr_c,
    input  logic             lvl_enable,
    input  logic             lvl_wait,
    input  logic             lvl_disable,
    input  logic             lvl_halt,
    input  logic             irq_enter,
    input  logic [1:0]       irq_lvl,
    input  logic             restore_en,
    input  logic [7:0]       restore_byte,
    input  logic             irq_pend,
    input  logic [1:0]       req_lvl,
    output logic [7:0]       ccr_q,
    output logic             irq_accept,
    output logic             br_c,
    output logic             br_nc,
    output logic             br_h,
    output logic             br_nh,
    output logic             br_z,
    output logic             br_nz,
    output logic             br_mi,
    output logic             br_pl
);
    ccr_state_t   st_q;
    ccr_state_t   st_d;
    arith_flags_t flags_alu;
    lvl_code_t    lvl_cmd;

    ccr_flag_next #(.RES_W(RES_W)) u_flags (
        .cur   (st_q.flags),
        .op    (op_class_e'(alu_op)),
        .res   (alu_res),
        .alu_c (alu_c),
        .alu_h (alu_h),
        .set_c (set_c),
        .clr_c (clr_c),
        .nxt   (flags_alu)
    );

    ccr_level_next u_level (
        .cur         (st_q.lvl),
        .lvl_enable  (lvl_enable),
        .lvl_wait    (lvl_wait),
        .lvl_disable (lvl_disable),
        .lvl_halt    (lvl_halt),
        .nxt         (lvl_cmd)
    );

    // Source priority: entry, then restore, then commands and ALU
    always_comb begin
        st_d = st_q;
        if (irq_enter) begin
            st_d.lvl = irq_lvl;
        end else if (restore_en) begin
            st_d = ccr_unpack(restore_byte);
        end else begin
            st_d.flags = flags_alu;
            st_d.lvl   = lvl_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CCR_RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ccr_q = ccr_pack(st_q);

    ccr_irq_gate u_gate (
        .cur    (st_q.lvl),
        .pend   (irq_pend),
        .req    (req_lvl),
        .accept (irq_accept)
    );

    ccr_branch u_branch (
        .flags (st_q.flags),
        .br_c  (br_c),
        .br_nc (br_nc),
        .br_h  (br_h),
        .br_nh (br_nh),
        .br_z  (br_z),
        .br_nz (br_nz),
        .br_mi (br_mi),
        .br_pl (br_pl)
    );
endmodule

// File: rtl/ccr_core_chk.sv
module ccr_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] alu_op,
    input logic       irq_enter,
    input logic [1:0] irq_lvl,
    input logic       restore_en,
    input logic [7:0] restore_byte,
    input logic [7:0] ccr_q,
    input logic       irq_accept,
    input logic       br_c,
    input logic       br_nc,
    input logic       br_h,
    input logic       br_nh,
    input logic       br_z,
    input logic       br_nz,
    input logic       br_mi,
    input logic       br_pl
);
    // R1
    fixed_ones_chk: assert property (@(posedge clk) disable iff (rst)
        ccr_q[7:6] == 2'b11);

    // R2
    reset_val_chk: assert property (@(posedge clk)
        rst |=> ccr_q == 8'hE8);

    // R3
    h_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_enter && !restore_en && alu_op != 3'd1) |=> $stable(ccr_q[4]));

    // R8
    entry_load_chk: assert property (@(posedge clk) disable iff (rst)
        irq_enter |=> ({ccr_q[5], ccr_q[3]} == $past(irq_lvl)));

    // R9
    restore_load_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_en && !irq_enter) |=> ccr_q == ($past(restore_byte) | 8'hC0));

    // R10
    masked_level_chk: assert property (@(posedge clk) disable iff (rst)
        (ccr_q[5] && ccr_q[3]) |-> !irq_accept);

    // R11
    br_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (br_c ^ br_nc) && (br_h ^ br_nh) && (br_z ^ br_nz) && (br_mi ^ br_pl)
        && (br_c == ccr_q[0]) && (br_z == ccr_q[1]) && (br_mi == ccr_q[2]) && (br_h == ccr_q[4]));
endmodule

bind ccr_core ccr_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .alu_op       (alu_op),
    .irq_enter    (irq_enter),
    .irq_lvl      (irq_lvl),
    .restore_en   (restore_en),
    .restore_byte (restore_byte),
    .ccr_q        (ccr_q),
    .irq_accept   (irq_accept),
    .br_c         (br_c),
    .br_nc        (br_nc),
    .br_h         (br_h),
    .br_nh        (br_nh),
    .br_z         (br_z),
    .br_nz        (br_nz),
    .br_mi        (br_mi),
    .br_pl        (br_pl)
);

// File: tb/ccr_core_bench.sv
`timescale 1ns/1ps
module ccr_core_bench;
    localparam int RES_W = 8;
    localparam int NVEC  = 12;

    // {op[3], res[8], c, h, set_c, clr_c, expected byte[8]}
    localparam logic [22:0] VEC [NVEC] = '{
        {3'd1, 8'h00, 4'b1100, 8'hFB},   // R3 R4 R5 add, zero result
        {3'd3, 8'h80, 4'b0000, 8'hFD},   // R4 logical keeps H and C
        {3'd2, 8'h05, 4'b0100, 8'hF8},   // R3 arithmetic keeps H
        {3'd1, 8'h7F, 4'b0000, 8'hE8},   // R3 add clears H
        {3'd4, 8'h00, 4'b1100, 8'hEB},   // R5 shift loads C
        {3'd5, 8'hFF, 4'b0100, 8'hEA},   // R4 R5 bit-test touches C only
        {3'd0, 8'h80, 4'b1100, 8'hEA},   // R4 none class holds all
        {3'd1, 8'h90, 4'b0110, 8'hFD},   // R6 set over ALU carry 0
        {3'd2, 8'h00, 4'b1001, 8'hFA},   // R6 clear over ALU carry 1
        {3'd0, 8'h00, 4'b0010, 8'hFB},   // R6 set alone
        {3'd0, 8'h00, 4'b0001, 8'hFA},   // R6 clear alone
        {3'd0, 8'h00, 4'b0011, 8'hFB}    // R6 both, set wins
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       alu_op = '0;
    logic [RES_W-1:0] alu_res = '0;
    logic             alu_c = 1'b0;
    logic             alu_h = 1'b0;
    logic             set_c = 1'b0;
    logic             clr_c = 1'b0;
    logic             lvl_enable = 1'b0;
    logic             lvl_wait = 1'b0;
    logic             lvl_disable = 1'b0;
    logic             lvl_halt = 1'b0;
    logic             irq_enter = 1'b0;
    logic [1:0]       irq_lvl = '0;
    logic             restore_en = 1'b0;
    logic [7:0]       restore_byte = '0;
    logic             irq_pend = 1'b0;
    logic [1:0]       req_lvl = '0;
    logic [7:0]       ccr_q;
    logic             irq_accept;
    logic             br_c, br_nc, br_h, br_nh, br_z, br_nz, br_mi, br_pl;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ccr_core #(.RES_W(RES_W)) u_ccr_core (
        .clk (clk), .rst (rst),
        .alu_op (alu_op), .alu_res (alu_res), .alu_c (alu_c), .alu_h (alu_h),
        .set_c (set_c), .clr_c (clr_c),
        .lvl_enable (lvl_enable), .lvl_wait (lvl_wait),
        .lvl_disable (lvl_disable), .lvl_halt (lvl_halt),
        .irq_enter (irq_enter), .irq_lvl (irq_lvl),
        .restore_en (restore_en), .restore_byte (restore_byte),
        .irq_pend (irq_pend), .req_lvl (req_lvl),
        .ccr_q (ccr_q), .irq_accept (irq_accept),
        .br_c (br_c), .br_nc (br_nc), .br_h (br_h), .br_nh (br_nh),
        .br_z (br_z), .br_nz (br_nz), .br_mi (br_mi), .br_pl (br_pl)
    );

    task automatic check8(string tag, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic idle();
        alu_op = '0; alu_res = '0; alu_c = 0; alu_h = 0; set_c = 0; clr_c = 0;
        lvl_enable = 0; lvl_wait = 0; lvl_disable = 0; lvl_halt = 0;
        irq_enter = 0; irq_lvl = '0; restore_en = 0; restore_byte = '0;
    endtask

    // Inputs already set at a falling edge; apply one rising edge, return at next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic acc(string tag, logic pend, logic [1:0] req, logic exp);
        irq_pend = pend;
        req_lvl  = req;
        #1;
        check8(tag, {7'd0, irq_accept}, {7'd0, exp});
        irq_pend = 0;
    endtask

    function automatic logic [7:0] br_vec();
        return {br_c, br_nc, br_h, br_nh, br_z, br_nz, br_mi, br_pl};
    endfunction

    initial begin
        idle();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check8("R2 reset value", ccr_q, 8'hE8);
        check8("R1 fixed ones after reset", {6'd0, ccr_q[7:6]}, 8'h03);

        for (int i = 0; i < NVEC; i++) begin
            alu_op  = VEC[i][22:20];
            alu_res = VEC[i][19:12];
            alu_c   = VEC[i][11];
            alu_h   = VEC[i][10];
            set_c   = VEC[i][9];
            clr_c   = VEC[i][8];
            step();
            check8($sformatf("R3/R4/R5/R6 vector %0d", i), ccr_q, VEC[i][7:0]);
        end

        // R7 enable writes level 0
        lvl_enable = 1;
        step();
        check8("R7 enable to level 0", ccr_q, 8'hF3);
        acc("R10 same level refused", 1, 2'b10, 0);
        acc("R10 higher level taken", 1, 2'b01, 1);

        // R8 entry beats restore, commands and ALU
        irq_enter = 1; irq_lvl = 2'b01;
        restore_en = 1; restore_byte = 8'hFF;
        alu_op = 3'd1; alu_res = 8'h00; alu_c = 0; alu_h = 0; clr_c = 1; lvl_disable = 1;
        step();
        check8("R8 entry loads level only", ccr_q, 8'hDB);
        acc("R10 equal level 1 refused", 1, 2'b01, 0);
        acc("R10 level 2 over level 1", 1, 2'b00, 1);

        // R7 disable wins over enable
        lvl_disable = 1; lvl_enable = 1;
        step();
        check8("R7 disable over enable", ccr_q, 8'hFB);
        acc("R10 level 3 masks all", 1, 2'b11, 0);

        lvl_wait = 1;
        step();
        check8("R7 wait to level 0", ccr_q, 8'hF3);
        lvl_halt = 1;
        step();
        check8("R7 halt to level 3", ccr_q, 8'hFB);

        // R9 restore beats ALU and explicit carry
        restore_en = 1; restore_byte = 8'h15;
        alu_op = 3'd1; alu_res = 8'h00; alu_c = 0; alu_h = 0; clr_c = 1; lvl_enable = 1;
        step();
        check8("R9 restore with forced top bits", ccr_q, 8'hD5);
        check8("R11 branch pairs after restore", br_vec(), 8'b1010_0110);

        restore_en = 1; restore_byte = 8'h00;
        step();
        check8("R9 restore zero byte", ccr_q, 8'hC0);
        check8("R11 branch pairs all clear", br_vec(), 8'b0101_0101);
        acc("R10 level 3 request over level 2", 1, 2'b11, 1);
        acc("R10 equal level 2 refused", 1, 2'b00, 0);
        acc("R10 no pending request", 0, 2'b11, 0);

        // R2 reset wins over a restore in the same cycle
        rst = 1; restore_en = 1; restore_byte = 8'h3F;
        step();
        rst = 0;
        check8("R2 reset over restore", ccr_q, 8'hE8);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule